// File: doc/BRIEF.md
# Dual Timer Transmit Output Combiner

This block is the transmit half of a paired timer used to synthesise an infrared carrier and its envelope. An 8-bit and a 16-bit down-counter each flip their own output level every time they run out, then reload from a value supplied on a dedicated input bus. The two levels are merged through one of four two-input logic functions, and the result, or a plain general-purpose port bit, is driven onto the transmit pin.

An 8-bit control word written through a single-cycle write strobe selects the behaviour. One bit hands the counters to a separate demodulation path, which freezes the transmit state. One bit chooses the pin source. A 2-bit field picks the merge function. A 2-bit submode runs the timers independently or alternately (ping-pong), or pins the 16-bit output to a fixed level. Two bits give the level each timer output takes when counting begins. Every write in transmit operation presets each output to the inverse of its start level, so the following start always shows as an edge. Counting advances only on cycles where the `tick` clock enable is high.

Top module: `ir_tx_combiner`

## Requirements
- R1: After reset the control word is 0, both timers are stopped, `t8_out` and `t16_out` are 0 and `tx_pin` equals `port_bit`.
- R2: Control bit 7 is the mode bit (0 = transmit) and bit 6 selects the pin source. `tx_pin` carries the merged timer output only when bit 7 = 0 and bit 6 = 1; otherwise it carries `port_bit`.
- R3: Control bits [5:4] select the merge: 00 = AND, 01 = OR, 10 = NOR, 11 = NAND of `t8_out` and `t16_out`.
- R4: A control write with bit 7 = 0 sets `t8_out` to the inverse of bit 0 on that edge. When submode bits [3:2] are 00 or 01, the same write sets `t16_out` to the inverse of bit 1.
- R5: In submodes 00, 10 and 11, a rising edge on `t8_en` loads the 8-bit counter from `t8_reload` and sets `t8_out` to control bit 0. In submode 00, a rising edge on `t16_en` does the same for the 16-bit counter with `t16_reload` and bit 1. While its enable is low, a timer is stopped.
- R6: A running timer decrements only on cycles with `tick` high. On a tick at count zero it inverts its output and reloads, so its output toggles every reload+1 ticks.
- R7: In submode 01, a rising `t8_en` starts the 8-bit timer, stops the 16-bit timer and sets both outputs to their start levels. The 8-bit timer's terminal count toggles `t8_out`, stops it and starts the 16-bit timer from its reload value. The 16-bit timer's terminal count toggles `t16_out` and restarts the 8-bit timer. `t16_en` is ignored, and `t8_en` low stops both.
- R8: Writing submode 00 while submode 01 is active stops both timers; they stay stopped until a new enable rising edge.
- R9: Submode 10 or 11 drives `t16_out` to 0 or 1 respectively from the write edge on and stops the 16-bit timer. The 8-bit timer keeps running.
- R10: While bit 7 = 1, outputs, counters and run states hold. A write that sets bit 7 does not preset the outputs.
- R11: In a cycle with a control write, no counter advances and no enable edge takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word written when `ctl_we` is high |
| tick | input | 1 | Count enable for both timers |
| t8_en | input | 1 | Run request of the 8-bit timer (also starts ping-pong) |
| t16_en | input | 1 | Run request of the 16-bit timer |
| t8_reload | input | W8 (8) | Reload value of the 8-bit timer |
| t16_reload | input | W16 (16) | Reload value of the 16-bit timer |
| port_bit | input | 1 | General-purpose level for the pin |
| tx_pin | output | 1 | Transmit pin |
| t8_out | output | 1 | 8-bit timer output level |
| t16_out | output | 1 | 16-bit timer output level |

## Verification
The hardest state to reach is a control write that leaves ping-pong for normal submode partway through a sequence. Both timers must then remain frozen even though `t8_en` stays high. The stimulus starts ping-pong with short reload values, lets several hand-overs occur, and then writes normal submode while the 16-bit timer is active. A behavioural reference model checks that neither output moves until the enable is cycled. Freeze mode is also entered while timers are active, with `port_bit` and the enables toggled, to show that nothing leaks through.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  localparam int CTL_W = 8;

  typedef enum logic [1:0] {
    CMB_AND  = 2'b00,
    CMB_OR   = 2'b01,
    CMB_NOR  = 2'b10,
    CMB_NAND = 2'b11
  } comb_e;

  typedef enum logic [1:0] {
    SUB_NORMAL   = 2'b00,
    SUB_PINGPONG = 2'b01,
    SUB_FORCE0   = 2'b10,
    SUB_FORCE1   = 2'b11
  } sub_e;

  // bit 7 mode, 6 pin source, 5:4 merge, 3:2 submode, 1 start16, 0 start8
  typedef struct packed {
    logic  demod;
    logic  pin_timers;
    comb_e comb;
    sub_e  sub;
    logic  start16;
    logic  start8;
  } ctl_t;

endpackage

// File: rtl/ir_down_timer.sv
module ir_down_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] reload,
  output logic         at_zero
);

  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load) begin
      cnt_n = reload;
    end else if (step) begin
      if (cnt_q == '0) cnt_n = reload;
      else             cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign at_zero = (cnt_q == '0);

  // R6: terminal count wraps to the reload value
  p_wrap_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && at_zero) |=> (cnt_q == $past(reload)));

  // R6: a step below terminal count decrements by one
  p_step_dec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq
  import ir_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ctl_t ctl,
  input  logic ctl_we,
  input  ctl_t wctl,
  input  logic tick,
  input  logic en8,
  input  logic en16,
  input  logic zero8,
  input  logic zero16,
  output logic load8,
  output logic step8,
  output logic load16,
  output logic step16,
  output logic o8,
  output logic o16
);

  logic en8_q, en16_q;
  logic act8_q, act8_n, act16_q, act16_n;
  logic o8_q, o8_n, o16_q, o16_n;
  logic rise8, rise16;

  assign rise8  = en8  & ~en8_q;
  assign rise16 = en16 & ~en16_q;

  always_comb begin
    act8_n  = act8_q;
    act16_n = act16_q;
    o8_n    = o8_q;
    o16_n   = o16_q;
    load8   = 1'b0;
    step8   = 1'b0;
    load16  = 1'b0;
    step16  = 1'b0;

    if (ctl_we) begin
      if (!wctl.demod) begin
        o8_n = ~wctl.start8;
        unique case (wctl.sub)
          SUB_NORMAL, SUB_PINGPONG: o16_n = ~wctl.start16;
          SUB_FORCE0:               o16_n = 1'b0;
          SUB_FORCE1:               o16_n = 1'b1;
        endcase
        if (wctl.sub[1]) act16_n = 1'b0;
        if (ctl.sub == SUB_PINGPONG && wctl.sub == SUB_NORMAL) begin
          act8_n  = 1'b0;
          act16_n = 1'b0;
        end
      end
    end else if (!ctl.demod) begin
      if (ctl.sub == SUB_PINGPONG) begin
        if (rise8) begin
          act8_n  = 1'b1;
          act16_n = 1'b0;
          load8   = 1'b1;
          o8_n    = ctl.start8;
          o16_n   = ctl.start16;
        end else if (!en8) begin
          act8_n  = 1'b0;
          act16_n = 1'b0;
        end else if (tick) begin
          if (act8_q) begin
            step8 = 1'b1;
            if (zero8) begin
              o8_n    = ~o8_q;
              act8_n  = 1'b0;
              act16_n = 1'b1;
              load16  = 1'b1;
            end
          end else if (act16_q) begin
            step16 = 1'b1;
            if (zero16) begin
              o16_n   = ~o16_q;
              act16_n = 1'b0;
              act8_n  = 1'b1;
              load8   = 1'b1;
            end
          end
        end
      end else begin
        // 8-bit timer runs on its own in every non-ping-pong submode
        if (rise8) begin
          act8_n = 1'b1;
          load8  = 1'b1;
          o8_n   = ctl.start8;
        end else if (!en8) begin
          act8_n = 1'b0;
        end else if (tick && act8_q) begin
          step8 = 1'b1;
          if (zero8) o8_n = ~o8_q;
        end

        if (ctl.sub[1]) begin
          act16_n = 1'b0;
          o16_n   = ctl.sub[0];
        end else if (rise16) begin
          act16_n = 1'b1;
          load16  = 1'b1;
          o16_n   = ctl.start16;
        end else if (!en16) begin
          act16_n = 1'b0;
        end else if (tick && act16_q) begin
          step16 = 1'b1;
          if (zero16) o16_n = ~o16_q;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en8_q   <= 1'b0;
      en16_q  <= 1'b0;
      act8_q  <= 1'b0;
      act16_q <= 1'b0;
      o8_q    <= 1'b0;
      o16_q   <= 1'b0;
    end else begin
      en8_q   <= en8;
      en16_q  <= en16;
      act8_q  <= act8_n;
      act16_q <= act16_n;
      o8_q    <= o8_n;
      o16_q   <= o16_n;
    end
  end

  assign o8  = o8_q;
  assign o16 = o16_q;

  // R7: ping-pong never runs both timers at once
  p_pp_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.sub == SUB_PINGPONG) |-> !(act8_q && act16_q));

  // R9: forced submode holds the 16-bit output at the forced level
  p_force_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !ctl.demod && ctl.sub[1]) |=> (o16_q == $past(ctl.sub[0])));

  // R10: demodulation mode freezes transmit state
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && ctl.demod) |=> ($stable(o8_q) && $stable(o16_q) && $stable(act8_q) && $stable(act16_q)));

  // R4: a transmit-mode write presets the 8-bit output to the inverse start level
  p_preset8_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !wctl.demod) |=> (o8_q == !$past(wctl.start8)));

  // R5: a low enable stops the 8-bit timer
  p_stop8_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_we && !ctl.demod && !en8) |=> !act8_q);

  // R11: no counting during a control write
  p_write_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |-> !(step8 || step16 || load8 || load16));

endmodule

// File: rtl/ir_out_mux.sv
module ir_out_mux
  import ir_tx_pkg::*;
(
  input  logic  a,
  input  logic  b,
  input  comb_e comb,
  input  logic  use_timers,
  input  logic  port_bit,
  output logic  pin
);

  logic merged;

  always_comb begin
    unique case (comb)
      CMB_AND:  merged = a & b;
      CMB_OR:   merged = a | b;
      CMB_NOR:  merged = ~(a | b);
      CMB_NAND: merged = ~(a & b);
    endcase
  end

  assign pin = use_timers ? merged : port_bit;

endmodule

// File: rtl/ir_tx_combiner.sv
module ir_tx_combiner
  import ir_tx_pkg::*;
#(
  parameter int W8  = 8,
  parameter int W16 = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             tick,
  input  logic             t8_en,
  input  logic             t16_en,
  input  logic [W8-1:0]    t8_reload,
  input  logic [W16-1:0]   t16_reload,
  input  logic             port_bit,
  output logic             tx_pin,
  output logic             t8_out,
  output logic             t16_out
);

  logic rs1_q, rs2_q, srst_n;
  ctl_t ctl_q, ctl_n, wctl;
  logic load8, step8, load16, step16;
  logic zero8, zero16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign srst_n = rs2_q;

  assign wctl = ctl_t'(ctl_wdata);

  always_comb begin
    ctl_n = ctl_q;
    if (ctl_we) ctl_n = wctl;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ctl_q <= '0;
    else         ctl_q <= ctl_n;
  end

  ir_down_timer #(.W(W8)) u_t8 (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (load8),
    .step    (step8),
    .reload  (t8_reload),
    .at_zero (zero8)
  );

  ir_down_timer #(.W(W16)) u_t16 (
    .clk     (clk),
    .rst_n   (srst_n),
    .load    (load16),
    .step    (step16),
    .reload  (t16_reload),
    .at_zero (zero16)
  );

  ir_tx_seq u_seq (
    .clk    (clk),
    .rst_n  (srst_n),
    .ctl    (ctl_q),
    .ctl_we (ctl_we),
    .wctl   (wctl),
    .tick   (tick),
    .en8    (t8_en),
    .en16   (t16_en),
    .zero8  (zero8),
    .zero16 (zero16),
    .load8  (load8),
    .step8  (step8),
    .load16 (load16),
    .step16 (step16),
    .o8     (t8_out),
    .o16    (t16_out)
  );

  ir_out_mux u_mux (
    .a          (t8_out),
    .b          (t16_out),
    .comb       (ctl_q.comb),
    .use_timers (ctl_q.pin_timers && !ctl_q.demod),
    .port_bit   (port_bit),
    .pin        (tx_pin)
  );

  // R2: demodulation mode hands the pin to the port bit
  p_pin_port_r2: assert property (@(posedge clk) disable iff (!srst_n)
    ctl_q.demod |-> (tx_pin == port_bit));

  // R1: the control word starts cleared after reset release
  p_ctl_reset_r1: assert property (@(posedge clk)
    ($rose(srst_n)) |-> (ctl_q == '0));

endmodule

// File: tb/tb_ir_tx_combiner.sv
module tb_ir_tx_combiner;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [7:0]  ctl_wdata;
  logic        tick;
  logic        t8_en, t16_en;
  logic [7:0]  t8_reload;
  logic [15:0] t16_reload;
  logic        port_bit;
  logic        tx_pin, t8_out, t16_out;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  ir_tx_combiner #(.W8(8), .W16(16)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .tick       (tick),
    .t8_en      (t8_en),
    .t16_en     (t16_en),
    .t8_reload  (t8_reload),
    .t16_reload (t16_reload),
    .port_bit   (port_bit),
    .tx_pin     (tx_pin),
    .t8_out     (t8_out),
    .t16_out    (t16_out)
  );

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_ctl;
  bit m_a8, m_a16, m_o8, m_o16, m_e8q, m_e16q, ms1, ms2;
  int m_c8, m_c16;

  task automatic m_clear();
    m_ctl = 8'h00; m_a8 = 0; m_a16 = 0; m_o8 = 0; m_o16 = 0;
    m_e8q = 0; m_e16q = 0; m_c8 = 0; m_c16 = 0;
  endtask

  task automatic m_step();
    bit r8, r16;
    logic [7:0] nw;
    r8  = t8_en  && !m_e8q;
    r16 = t16_en && !m_e16q;
    if (!rst_n) begin
      m_clear(); ms1 = 0; ms2 = 0;
      return;
    end
    if (!ms2) begin
      m_clear();
    end else if (ctl_we) begin
      nw = ctl_wdata;
      if (!nw[7]) begin
        m_o8 = !nw[0];
        if (nw[3:2] == 2'd2)      m_o16 = 0;
        else if (nw[3:2] == 2'd3) m_o16 = 1;
        else                      m_o16 = !nw[1];
        if (nw[3]) m_a16 = 0;
        if (m_ctl[3:2] == 2'd1 && nw[3:2] == 2'd0) begin m_a8 = 0; m_a16 = 0; end
      end
      m_ctl = nw;
    end else if (!m_ctl[7]) begin
      if (m_ctl[3:2] == 2'd1) begin
        if (r8) begin
          m_a8 = 1; m_a16 = 0; m_c8 = t8_reload; m_o8 = m_ctl[0]; m_o16 = m_ctl[1];
        end else if (!t8_en) begin
          m_a8 = 0; m_a16 = 0;
        end else if (tick) begin
          if (m_a8) begin
            if (m_c8 == 0) begin
              m_o8 = !m_o8; m_a8 = 0; m_a16 = 1; m_c16 = t16_reload; m_c8 = t8_reload;
            end else m_c8--;
          end else if (m_a16) begin
            if (m_c16 == 0) begin
              m_o16 = !m_o16; m_a16 = 0; m_a8 = 1; m_c8 = t8_reload; m_c16 = t16_reload;
            end else m_c16--;
          end
        end
      end else begin
        if (r8) begin m_a8 = 1; m_c8 = t8_reload; m_o8 = m_ctl[0]; end
        else if (!t8_en) m_a8 = 0;
        else if (tick && m_a8) begin
          if (m_c8 == 0) begin m_o8 = !m_o8; m_c8 = t8_reload; end else m_c8--;
        end
        if (m_ctl[3]) begin m_a16 = 0; m_o16 = m_ctl[2]; end
        else if (r16) begin m_a16 = 1; m_c16 = t16_reload; m_o16 = m_ctl[1]; end
        else if (!t16_en) m_a16 = 0;
        else if (tick && m_a16) begin
          if (m_c16 == 0) begin m_o16 = !m_o16; m_c16 = t16_reload; end else m_c16--;
        end
      end
    end
    if (ms2) begin m_e8q = t8_en; m_e16q = t16_en; end
    ms2 = ms1; ms1 = 1;
  endtask

  function automatic bit m_pin();
    bit mg;
    case (m_ctl[5:4])
      2'd0: mg = m_o8 & m_o16;
      2'd1: mg = m_o8 | m_o16;
      2'd2: mg = !(m_o8 | m_o16);
      default: mg = !(m_o8 & m_o16);
    endcase
    return (!m_ctl[7] && m_ctl[6]) ? mg : port_bit;
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    m_step();
    #2;
    if (!done) begin
      chk(t8_out == m_o8,    cur_req, "t8_out",  t8_out,  m_o8);
      chk(t16_out == m_o16,  cur_req, "t16_out", t16_out, m_o16);
      chk(tx_pin == m_pin(), cur_req, "tx_pin",  tx_pin,  m_pin());
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 0;
  endtask

  initial begin
    rst_n = 0; ctl_we = 0; ctl_wdata = 0; tick = 0; t8_en = 0; t16_en = 0;
    t8_reload = 8'd3; t16_reload = 16'd5; port_bit = 1;
    cyc(3);
    rst_n = 1;
    cyc(5);

    // R1: reset state
    cur_req = "R1";
    chk(t8_out == 0,  "R1", "t8_out after reset",  t8_out,  0);
    chk(t16_out == 0, "R1", "t16_out after reset", t16_out, 0);
    chk(tx_pin == 1,  "R1", "tx_pin follows port_bit", tx_pin, 1);
    port_bit = 0; #1;
    chk(tx_pin == 0,  "R1", "tx_pin follows port_bit low", tx_pin, 0);

    // R4: preset on write (pin from timers, AND, normal, starts 1/1)
    cur_req = "R4";
    wr(8'h43);
    chk(t8_out == 0 && t16_out == 0, "R4", "outputs preset to inverse", {t8_out, t16_out}, 0);

    // R5/R6: independent timers, dense then sparse ticks
    cur_req = "R5";
    @(negedge clk); t8_en = 1; t16_en = 1; tick = 1;
    @(negedge clk);
    chk(t8_out == 1 && t16_out == 1, "R5", "start level on enable", {t8_out, t16_out}, 3);
    cur_req = "R6";
    cyc(40);
    for (int i = 0; i < 60; i++) begin @(negedge clk); tick = (i % 3 == 0); end
    tick = 1;

    // R11: writes while counting
    cur_req = "R11";
    t8_reload = 8'd2;
    for (int i = 0; i < 4; i++) begin wr(8'h43); cyc(2); end
    cyc(10);

    // R3: all merge functions, pin source both ways
    cur_req = "R3";
    wr(8'h53); cyc(15);
    wr(8'h63); cyc(15);
    wr(8'h73); cyc(15);
    wr(8'h42); cyc(12);
    cur_req = "R2";
    wr(8'h03); port_bit = 1; cyc(6); port_bit = 0; cyc(6);
    wr(8'h43); cyc(6);

    // R7: ping-pong
    cur_req = "R7";
    t8_en = 0; t16_en = 0; cyc(2);
    t8_reload = 8'd2; t16_reload = 16'd4;
    wr(8'h45);
    @(negedge clk); t8_en = 1;
    cyc(3); t16_en = 1;
    for (int i = 0; i < 80; i++) begin @(negedge clk); tick = (i % 5 != 4); end
    tick = 1;
    t8_en = 0; cyc(4); t8_en = 1; cyc(12);   // R7 restart

    // R8: leave ping-pong mid sequence with enables still high
    cur_req = "R8";
    cyc(7);
    wr(8'h45 & 8'hF3);
    begin
      logic a, b;
      a = t8_out; b = t16_out;
      cyc(20);
      chk(t8_out == a && t16_out == b, "R8", "outputs frozen after leaving ping-pong",
          {t8_out, t16_out}, {a, b});
    end
    t8_en = 0; t16_en = 0; cyc(2); t8_en = 1; t16_en = 1; cyc(20);

    // R9: forced 16-bit output, 8-bit keeps going
    cur_req = "R9";
    wr(8'h49);
    chk(t16_out == 0, "R9", "force0 at write edge", t16_out, 0);
    cyc(20);
    wr(8'h4D);
    chk(t16_out == 1, "R9", "force1 at write edge", t16_out, 1);
    t16_en = 0; cyc(3); t16_en = 1; cyc(20);
    wr(8'h40); cyc(3); t16_en = 0; cyc(2); t16_en = 1; cyc(15);

    // R10: freeze
    cur_req = "R10";
    wr(8'hC3);
    begin
      logic a, b;
      a = t8_out; b = t16_out;
      port_bit = 1; cyc(3);
      chk(tx_pin == 1, "R10", "pin follows port in freeze", tx_pin, 1);
      t8_en = 0; cyc(3); t8_en = 1; port_bit = 0; cyc(10);
      wr(8'hC0);
      chk(t8_out == a && t16_out == b, "R10", "frozen outputs, no preset",
          {t8_out, t16_out}, {a, b});
    end
    wr(8'h43); cyc(30);

    done = 1;
    #3;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule